// File: doc/BRIEF.md
# Dual-Output Vectored Interrupt Controller

This block gathers up to 32 interrupt requests into a status register and drives two request lines toward a processor: a normal one and a critical one. Each source is captured as either edge-sensitive or level-sensitive, and its active polarity is programmable. An enable register masks the status. A per-source select register then sends every enabled, pending source to one of the two outputs.

For critical requests, the block forms a vector address. The address is a software-programmed base plus a 512-byte step for each position between the start of the scan and the first pending critical source. Software chooses which end of the status word the scan starts from.

Software reaches the registers over a plain single-cycle bus. A write is strobed by `wr_en` and takes effect at the next rising edge. `rd_data` follows `addr` combinationally. Both outputs and the vector are derived from registered state, so any write is visible on the following cycle.

Top module: `dual_irq_ctrl`

## Requirements
- R1: Source n (input `src_i[n]`) is reflected in status bit 31−n, so source 0 owns the most significant bit. Register offsets are: 0 status, 1 enable, 2 critical select, 3 polarity, 4 trigger mode, 5 masked status (read only), 6 vector configuration, 7 vector (read only).
- R2: Polarity and edge capture work as follows. A polarity bit of 1 makes the source active high; 0 makes it active low. With its trigger bit at 1, a source sets its status bit on the cycle its input moves into the active level. Moving out of the active level does not set the bit. Rewriting the polarity does not count as a transition.
- R3: With its trigger bit at 0, a source sets its status bit while its input is active. Writing a 1 to that bit while the input stays active leaves it set.
- R4: Writing the status register clears each bit written as 1 and leaves bits written as 0 unchanged.
- R5: Offset 5 reads status AND enable. `irq_o` is high when status AND enable AND NOT critical-select is nonzero.
- R6: `crit_irq_o` is high when status AND enable AND critical-select is nonzero.
- R7: When vector-configuration bit 0 is 1, the vector is that register with its low two bits cleared, plus 512 × (31 − b). Here b is the highest pending critical status bit.
- R8: When vector-configuration bit 0 is 0, the vector is the cleared base plus 512 × b. Here b is the lowest pending critical status bit.
- R9: A write to the vector configuration stores bit 1 as zero. The vector reads as zero whenever no critical request is pending.
- R10: Reset clears the status, enable, critical-select, polarity, trigger and vector-configuration registers, so every readable offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Interrupt source inputs, index = source number |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register offset |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr` |
| irq_o | output | 1 | Normal interrupt request |
| crit_irq_o | output | 1 | Critical interrupt request |

## Verification
The bench sweeps every source through edge capture, level capture and the vector computation in both scan directions.

- A reversed bit map would show up as a wrong status bit on the first single-source pulse.
- A vector scanned from the wrong end would be caught by two sources pending together, because the two directions pick different winners.
- A level source that the status write fails to re-set would read as clear after the write.
- Edge logic that compares against the old polarity would raise status when the polarity register is rewritten.

// File: rtl/dual_irq_ctrl.sv
module dual_irq_ctrl #(
  parameter int NSRC   = 32,
  parameter int DW     = 32,
  parameter int AW     = 3,
  parameter int VSHIFT = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wr_data,
  output logic [DW-1:0]   rd_data,
  output logic            irq_o,
  output logic            crit_irq_o
);
  localparam int IW = $clog2(NSRC);
  localparam logic [AW-1:0] A_STAT = AW'(0);
  localparam logic [AW-1:0] A_EN   = AW'(1);
  localparam logic [AW-1:0] A_CRIT = AW'(2);
  localparam logic [AW-1:0] A_POL  = AW'(3);
  localparam logic [AW-1:0] A_TRIG = AW'(4);
  localparam logic [AW-1:0] A_MSK  = AW'(5);
  localparam logic [AW-1:0] A_VCFG = AW'(6);
  localparam logic [AW-1:0] A_VEC  = AW'(7);
  localparam logic [DW-1:0] VCFG_KEEP = {{(DW-2){1'b1}}, 2'b01};

  logic [NSRC-1:0] st_q, en_q, crit_q, pol_q, trig_q, src_q;
  logic [DW-1:0]   vcfg_q;
  logic [NSRC-1:0] act_now, act_prev, clr, pend_n, pend_c;
  logic [IW-1:0]   hi_idx, lo_idx, pos;
  logic [DW-1:0]   vec;

  // sources in bit-reversed order; active when input equals polarity bit
  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      act_now[NSRC-1-i]  = src_i[i] ~^ pol_q[NSRC-1-i];
      act_prev[NSRC-1-i] = src_q[i] ~^ pol_q[NSRC-1-i];
    end
  end

  assign clr    = (wr_en && addr == A_STAT) ? wr_data[NSRC-1:0] : '0;
  assign pend_n = st_q & en_q & ~crit_q;
  assign pend_c = st_q & en_q & crit_q;
  assign irq_o      = |pend_n;
  assign crit_irq_o = |pend_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= '0;
      en_q   <= '0;
      crit_q <= '0;
      pol_q  <= '0;
      trig_q <= '0;
      src_q  <= '0;
      vcfg_q <= '0;
    end else begin
      src_q <= src_i;
      st_q  <= (st_q & ~clr) | (~trig_q & act_now) | (trig_q & act_now & ~act_prev);
      if (wr_en) begin
        case (addr)
          A_EN:    en_q   <= wr_data[NSRC-1:0];
          A_CRIT:  crit_q <= wr_data[NSRC-1:0];
          A_POL:   pol_q  <= wr_data[NSRC-1:0];
          A_TRIG:  trig_q <= wr_data[NSRC-1:0];
          A_VCFG:  vcfg_q <= wr_data & VCFG_KEEP;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    hi_idx = '0;
    lo_idx = '0;
    for (int i = 0; i < NSRC; i++)
      if (pend_c[i]) hi_idx = IW'(i);
    for (int i = NSRC-1; i >= 0; i--)
      if (pend_c[i]) lo_idx = IW'(i);
    pos = vcfg_q[0] ? (IW'(NSRC-1) - hi_idx) : lo_idx;
    vec = crit_irq_o ? ({vcfg_q[DW-1:2], 2'b00} + (DW'(pos) << VSHIFT)) : '0;
  end

  always_comb begin
    case (addr)
      A_STAT:  rd_data = DW'(st_q);
      A_EN:    rd_data = DW'(en_q);
      A_CRIT:  rd_data = DW'(crit_q);
      A_POL:   rd_data = DW'(pol_q);
      A_TRIG:  rd_data = DW'(trig_q);
      A_MSK:   rd_data = DW'(st_q & en_q);
      A_VCFG:  rd_data = vcfg_q;
      A_VEC:   rd_data = vec;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/dual_irq_ctrl_chk.sv
module dual_irq_ctrl_chk #(
  parameter int NSRC = 32,
  parameter int DW   = 32,
  parameter int AW   = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            irq_o,
  input logic            crit_irq_o,
  input logic            wr_en,
  input logic [AW-1:0]   addr,
  input logic [DW-1:0]   wr_data,
  input logic [NSRC-1:0] st,
  input logic [NSRC-1:0] en,
  input logic [NSRC-1:0] crit,
  input logic [NSRC-1:0] pol,
  input logic [NSRC-1:0] trig,
  input logic [NSRC-1:0] act,
  input logic [DW-1:0]   vcfg,
  input logic [DW-1:0]   vec
);
  localparam logic [DW-1:0] KEEP = {{(DW-2){1'b1}}, 2'b01};

  // R10
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (st == '0 && en == '0 && crit == '0 && pol == '0 && trig == '0 && vcfg == '0));

  // R3
  level_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((~$past(trig) & $past(act)) & ~st) == '0));

  // R5
  out_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o || crit_irq_o) |-> (en != '0 && st != '0));

  // R9
  vcfg_bit1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(6)) |=> (vcfg == ($past(wr_data) & KEEP)));

  // R9
  vec_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !crit_irq_o |-> (vec == '0));
endmodule

bind dual_irq_ctrl dual_irq_ctrl_chk #(.NSRC(NSRC), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .crit_irq_o(crit_irq_o),
  .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .st(st_q), .en(en_q), .crit(crit_q), .pol(pol_q), .trig(trig_q),
  .act(act_now), .vcfg(vcfg_q), .vec(vec)
);

// File: tb/sim_dual_irq_ctrl.sv
module sim_dual_irq_ctrl;
  logic        clk = 0, rst_n = 0;
  logic [31:0] src = '1;
  logic        wr_en = 0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  wire  [31:0] rdata;
  wire         irq, cirq;
  int checks = 0, fails = 0;
  bit done = 0;

  dual_irq_ctrl u0 (.clk(clk), .rst_n(rst_n), .src_i(src), .wr_en(wr_en), .addr(addr),
                    .wr_data(wdata), .rd_data(rdata), .irq_o(irq), .crit_irq_o(cirq));

  always #4 clk = ~clk;

  function automatic logic [31:0] rev(logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[31-i] = v[i];
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic pulse(logic [31:0] m);
    @(negedge clk); src = src | m;
    @(negedge clk); src = src & ~m;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, st, base;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 every offset zero after reset
    for (int a = 0; a < 8; a++) begin rd(3'(a), v); chk("R10", v, 32'h0); end
    chk("R10 outs", {30'h0, irq, cirq}, 32'h0);

    wr(3'd4, '1); wr(3'd3, '1);
    @(negedge clk); src = '0;
    repeat (2) @(negedge clk);
    rd(3'd0, v); chk("R2 polarity rewrite no edge", v, 32'h0);

    // R1 R2 R4 edge sweep
    for (int n = 0; n < 32; n++) begin
      pulse(32'h1 << n);
      rd(3'd0, v); chk("R1 R2 edge bit", v, 32'h1 << (31 - n));
      wr(3'd0, 32'h1 << (31 - n));
      rd(3'd0, v); chk("R4 clear", v, 32'h0);
    end

    // R2 active-low edge on source 0
    wr(3'd3, 32'h7FFF_FFFF);
    @(negedge clk); src[0] = 1;
    @(negedge clk); rd(3'd0, v); chk("R2 leaving active", v, 32'h0);
    @(negedge clk); src[0] = 0;
    @(negedge clk); rd(3'd0, v); chk("R2 active-low edge", v, 32'h8000_0000);
    wr(3'd0, '1); wr(3'd3, '1);
    rd(3'd0, v); chk("R4 clear all", v, 32'h0);

    // R3 level sweep
    for (int n = 0; n < 32; n++) begin
      wr(3'd4, ~(32'h1 << (31 - n)));
      @(negedge clk); src[n] = 1;
      @(negedge clk); rd(3'd0, v); chk("R3 level set", v, 32'h1 << (31 - n));
      wr(3'd0, 32'h1 << (31 - n));
      rd(3'd0, v); chk("R3 level held", v, 32'h1 << (31 - n));
      src[n] = 0;
      wr(3'd0, 32'h1 << (31 - n));
      rd(3'd0, v); chk("R4 level clear", v, 32'h0);
      wr(3'd4, '1);
    end

    // R4 partial clear: bits written 0 stay
    pulse(32'h0000_0003);
    wr(3'd0, 32'h8000_0000);
    rd(3'd0, v); chk("R4 partial", v, 32'h4000_0000);
    wr(3'd0, '1);

    // R5 R6 mask and output patterns
    for (int p = 0; p < 6; p++) begin
      logic [31:0] sp, e, c;
      sp = 32'hA5C3_0F1E ^ (32'h1357_9BDF * p);
      e  = 32'hF0F0_33CC ^ (32'h0246_8ACE * p);
      c  = (p == 5) ? 32'h0 : (32'h3C3C_A55A ^ (32'h1111_1111 * p));
      wr(3'd1, e); wr(3'd2, c);
      pulse(sp);
      st = rev(sp);
      rd(3'd5, v); chk("R5 masked", v, st & e);
      chk("R5 irq", {31'h0, irq}, {31'h0, |(st & e & ~c)});
      chk("R6 crit", {31'h0, cirq}, {31'h0, |(st & e & c)});
      wr(3'd0, '1);
    end

    // R7 R8 vector sweep
    wr(3'd1, '1); wr(3'd2, '1);
    base = 32'hC001_2340;
    for (int n = 0; n < 32; n++) begin
      pulse(32'h1 << n);
      wr(3'd6, base | 32'h1);
      rd(3'd7, v); chk("R7 vector high-first", v, base + 32'(512 * n));
      wr(3'd6, base | 32'h2);
      rd(3'd7, v); chk("R8 vector low-first", v, base + 32'(512 * (31 - n)));
      wr(3'd0, '1);
    end
    pulse((32'h1 << 5) | (32'h1 << 20));
    wr(3'd6, base | 32'h3);
    rd(3'd7, v); chk("R7 two pending", v, base + 32'(512 * 5));
    wr(3'd6, base);
    rd(3'd7, v); chk("R8 two pending", v, base + 32'(512 * 11));
    wr(3'd1, '0);
    rd(3'd7, v); chk("R9 disabled vector", v, 32'h0);
    wr(3'd0, '1);

    // R9 config write masking and idle vector
    wr(3'd6, '1);
    rd(3'd6, v); chk("R9 vcfg bit1", v, 32'hFFFF_FFFD);
    rd(3'd7, v); chk("R9 idle vector", v, 32'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule